// File: doc/BRIEF.md
# Pulse-Burst Clock Gate

This block passes a free-running source clock to a gated output clock. The output either follows the source continuously or, for single-stepping and throttling logic under debug, delivers a programmed number of pulses and then stops. Software drives it through a plain register port. One register holds the pulse count. A control register holds a start bit and a counter-clear bit. A status register reports how many burst pulses have been produced and whether a counted burst is under way. An asynchronous stop input can end a burst early.

A burst is launched by a 0-to-1 transition of the start bit. A count of zero selects continuous clocking. The gate enable is a flop whose value is captured by a latch that is transparent only while the source clock is low. Every output pulse is therefore a full source high phase.

Top module: `pbg_top`

## Requirements
- R1: After reset the output clock runs continuously (one output pulse per source cycle), the status count (status bits [15:0], address 2) reads 0, and the running flag (status bit 16 and the `running` port) is 0.
- R2: A write to the count register (address 0, data bits [15:0]) stops the output clock from the cycle after the write, whatever the current mode.
- R3: Writing 1 to the start bit (address 1, bit 0) when its last written value was 0, with a count N from 1 to 65535, produces exactly N output pulses starting on the next source cycle and then halts; `running` is 1 from the cycle after the write until the halt.
- R4: Writing 1 to the start bit when its last written value was already 1 has no effect on the output clock.
- R5: A start transition with a count of 0 selects continuous clocking with `running` at 0.
- R6: A rising edge on `trigIn`, passed through a two-flop synchronizer, ends a counted burst. If the edge is set up before source edge a, the last pulse falls on edge a+2.
- R7: Writing 1 to the clear bit (address 1, bit 1) while halted zeroes the status count at once. If the write comes during a burst or continuous clocking, the clear waits until the block next halts. Writing 0 to the clear bit leaves the count unchanged.
- R8: The status count adds one for each output pulse of a counted burst and accumulates across bursts. It does not change while the clock is halted unless there is a register write.
- R9: Reading address 1 returns the last value written to the start bit in bit 0.
- R10: The gate enable seen by the output clock is the value captured during the preceding source low phase, so no truncated pulse appears.
- R11: A rising edge on `trigIn` outside a counted burst has no effect on continuous clocking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running source clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe, sampled on the rising edge |
| wrAddr | input | 2 | Write address: 0 count, 1 control |
| wrData | input | CNT_W | Write data |
| rdAddr | input | 2 | Read address: 0 count, 1 control, 2 status |
| rdData | output | CNT_W+1 | Combinational read data |
| trigIn | input | 1 | Asynchronous burst stop trigger |
| gclk | output | 1 | Gated output clock |
| clkEn | output | 1 | Registered gate enable |
| running | output | 1 | Counted burst in progress |

## Verification
The bench changes inputs on falling edges, and a write is taken on the rising edge that follows. State therefore changes one edge after the write: halting, entering a burst and an immediate clear all land on that edge. A burst of N puts its pulses on the next N rising edges, so the bench checks the pulse tally N+3 cycles later. A trigger set up before edge a stops the burst at edge a+2, which gives a known tally of m+3 when the trigger is raised m cycles after the start. Reads are combinational, and the bench takes them one time step after setting the address, half a cycle away from any edge.

// File: rtl/pbg_pkg.sv
package pbg_pkg;

  localparam logic [1:0] ADDR_COUNT  = 2'd0;
  localparam logic [1:0] ADDR_CTRL   = 2'd1;
  localparam logic [1:0] ADDR_STATUS = 2'd2;

  typedef enum logic [1:0] {
    ST_FREE  = 2'd0,
    ST_HALT  = 2'd1,
    ST_BURST = 2'd2
  } gateState_t;

  // strobes sent from control to datapath
  typedef struct packed {
    logic loadCount;
    logic loadStart;
    logic clrBurst;
    logic incPulse;
    logic clrTotal;
    logic setPend;
    logic clrPend;
  } strobes_t;

endpackage

// File: rtl/pbg_trig_sync.sv
module pbg_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic trigIn,
  output logic trigRise
);
  logic [STAGES-1:0] syncQ;
  logic              lastQ;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= trigIn;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[STAGES-2:0], trigIn};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastQ <= 1'b0;
    else       lastQ <= syncQ[STAGES-1];
  end

  assign trigRise = syncQ[STAGES-1] & ~lastQ;
endmodule

// File: rtl/pbg_ctrl.sv
module pbg_ctrl
  import pbg_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     wrEn,
  input  logic [1:0] wrAddr,
  input  logic     wrStart,
  input  logic     wrClear,
  input  logic     trigRise,
  input  logic     countZero,
  input  logic     lastPulse,
  input  logic     startBit,
  input  logic     pendClear,
  output strobes_t strb,
  output logic     clkEn,
  output logic     running
);
  gateState_t stateQ, stateD;
  logic wrCount, wrCtrl, startEdge, clearReq, enterHalt;

  always_comb begin
    wrCount   = wrEn && (wrAddr == ADDR_COUNT);
    wrCtrl    = wrEn && (wrAddr == ADDR_CTRL);
    startEdge = wrCtrl && wrStart && !startBit;
    clearReq  = wrCtrl && wrClear;
  end

  always_comb begin
    stateD = stateQ;
    if (wrCount)
      stateD = ST_HALT;
    else if (startEdge)
      stateD = countZero ? ST_FREE : ST_BURST;
    else if (stateQ == ST_BURST && (trigRise || lastPulse))
      stateD = ST_HALT;
  end

  always_comb begin
    enterHalt      = (stateD == ST_HALT) && (stateQ != ST_HALT);
    strb.loadCount = wrCount;
    strb.loadStart = wrCtrl;
    strb.clrBurst  = startEdge;
    strb.incPulse  = (stateQ == ST_BURST);
    strb.clrTotal  = (clearReq && stateQ == ST_HALT) ||
                     ((clearReq || pendClear) && enterHalt);
    strb.setPend   = clearReq && (stateQ != ST_HALT) && !enterHalt;
    strb.clrPend   = strb.clrTotal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_FREE;
    else       stateQ <= stateD;
  end

  assign clkEn   = (stateQ != ST_HALT);
  assign running = (stateQ == ST_BURST);
endmodule

// File: rtl/pbg_datapath.sv
module pbg_datapath
  import pbg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         strb,
  input  logic [CNT_W-1:0] wrData,
  input  logic [1:0]       rdAddr,
  input  logic             running,
  output logic             countZero,
  output logic             lastPulse,
  output logic             startBit,
  output logic             pendClear,
  output logic [CNT_W-1:0] pulseCnt,
  output logic [CNT_W:0]   rdData
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] countQ;
  logic [CNT_W-1:0] burstQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ   <= '0;
      startBit <= 1'b0;
    end else begin
      if (strb.loadCount) countQ   <= wrData;
      if (strb.loadStart) startBit <= wrData[0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              burstQ <= '0;
    else if (strb.clrBurst) burstQ <= '0;
    else if (strb.incPulse) burstQ <= burstQ + ONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              pulseCnt <= '0;
    else if (strb.clrTotal) pulseCnt <= '0;
    else if (strb.incPulse) pulseCnt <= pulseCnt + ONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             pendClear <= 1'b0;
    else if (strb.clrPend) pendClear <= 1'b0;
    else if (strb.setPend) pendClear <= 1'b1;
  end

  assign countZero = (countQ == '0);
  assign lastPulse = !countZero && (burstQ == countQ - ONE);

  always_comb begin
    rdData = '0;
    unique case (rdAddr)
      ADDR_COUNT:  rdData[CNT_W-1:0] = countQ;
      ADDR_CTRL:   rdData[0]         = startBit;
      ADDR_STATUS: rdData            = {running, pulseCnt};
      default:     rdData            = '0;
    endcase
  end
endmodule

// File: rtl/pbg_top.sv
module pbg_top
  import pbg_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic [1:0]       rdAddr,
  output logic [CNT_W:0]   rdData,
  input  logic             trigIn,
  output logic             gclk,
  output logic             clkEn,
  output logic             running
);
  strobes_t         strb;
  logic             trigRise, countZero, lastPulse, startBit, pendClear;
  logic [CNT_W-1:0] pulseCnt;
  logic             gateLat;

  pbg_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .trigRise(trigRise)
  );

  pbg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrStart(wrData[0]), .wrClear(wrData[1]), .trigRise(trigRise),
    .countZero(countZero), .lastPulse(lastPulse), .startBit(startBit),
    .pendClear(pendClear), .strb(strb), .clkEn(clkEn), .running(running)
  );

  pbg_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .rdAddr(rdAddr), .running(running), .countZero(countZero),
    .lastPulse(lastPulse), .startBit(startBit), .pendClear(pendClear),
    .pulseCnt(pulseCnt), .rdData(rdData)
  );

  // enable captured while the source is low; held through the high phase
  always_latch begin
    if (!clk) gateLat = clkEn;
  end

  assign gclk = clk & gateLat;
endmodule

// File: rtl/pbg_checker.sv
module pbg_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [1:0]       wrAddr,
  input logic             wrStart,
  input logic             startBit,
  input logic             clkEn,
  input logic             running,
  input logic             gateLat,
  input logic [CNT_W-1:0] pulseCnt
);
  assert_count_write_halts_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 2'd0) |=> !clkEn);

  assert_burst_gated_R3: assert property (@(posedge clk) disable iff (!rstN)
    running |-> clkEn);

  assert_rewrite_no_start_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEn && wrEn && wrAddr == 2'd1 && wrStart && startBit) |=> !clkEn);

  assert_halt_count_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEn && !wrEn) |=> $stable(pulseCnt));

  assert_burst_count_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    (running && !wrEn) |=> (pulseCnt == $past(pulseCnt) + 1'b1) || (pulseCnt == '0));

  assert_gate_latched_R10: assert property (@(posedge clk) disable iff (!rstN)
    gateLat == clkEn);
endmodule

bind pbg_top pbg_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrStart(wrData[0]),
  .startBit(startBit), .clkEn(clkEn), .running(running), .gateLat(gateLat),
  .pulseCnt(pulseCnt)
);

// File: tb/tb_pbg_top.sv
module tb_pbg_top;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             wrEn = 1'b0;
  logic [1:0]       wrAddr = '0;
  logic [CNT_W-1:0] wrData = '0;
  logic [1:0]       rdAddr = '0;
  logic [CNT_W:0]   rdData;
  logic             trigIn = 1'b0;
  logic             gclk, clkEn, running;

  int nChecks = 0;
  int nFails  = 0;
  int pulses  = 0;
  int p0;
  int expTotal;
  logic [CNT_W:0] rv;

  pbg_top #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .trigIn(trigIn), .gclk(gclk),
    .clkEn(clkEn), .running(running)
  );

  always #10 clk = ~clk;

  always @(posedge gclk) pulses++;

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = CNT_W'(d);
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [CNT_W:0] v);
    rdAddr = a;
    #1;
    v = rdData;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R1 reset state
    rd(2'd2, rv);
    chk("R1 status count", int'(rv[CNT_W-1:0]), 0);
    chk("R1 running", int'(running), 0);
    p0 = pulses; idle(10);
    chk("R1 free pulses", pulses - p0, 10);

    // R2 count write halts
    wr(2'd0, 7);
    chk("R2 clkEn", int'(clkEn), 0);
    p0 = pulses; idle(10);
    chk("R2 no pulses", pulses - p0, 0);

    // R9 readback of 0
    wr(2'd1, 0);
    rd(2'd1, rv);
    chk("R9 start reads 0", int'(rv[0]), 0);

    // R7 immediate clear while halted
    wr(2'd1, 2);
    rd(2'd2, rv);
    chk("R7 clear halted", int'(rv[CNT_W-1:0]), 0);

    // R3 / R8 sweep of burst lengths, accumulating
    expTotal = 0;
    for (int n = 1; n <= 24; n++) begin
      wr(2'd0, n);
      wr(2'd1, 0);
      p0 = pulses;
      wr(2'd1, 1);
      chk("R3 running during burst", int'(running), 1);
      idle(n + 3);
      chk("R3 burst pulses", pulses - p0, n);
      chk("R3 halted after burst", int'(running) + int'(clkEn), 0);
      expTotal += n;
      rd(2'd2, rv);
      chk("R8 accumulated count", int'(rv[CNT_W-1:0]), expTotal);
    end

    // R9 readback of 1
    rd(2'd1, rv);
    chk("R9 start reads 1", int'(rv[0]), 1);

    // R4 writing 1 again does nothing
    p0 = pulses;
    wr(2'd1, 1);
    idle(10);
    chk("R4 no restart pulses", pulses - p0, 0);
    chk("R4 clkEn", int'(clkEn), 0);

    // R7 deferred clear during a burst
    wr(2'd0, 20);
    wr(2'd1, 0);
    p0 = pulses;
    wr(2'd1, 1);
    idle(3);
    wr(2'd1, 2);
    chk("R7 clear does not halt", int'(running), 1);
    idle(25);
    chk("R7 burst completes", pulses - p0, 20);
    rd(2'd2, rv);
    chk("R7 deferred clear", int'(rv[CNT_W-1:0]), 0);

    // R7 writing 0 to the clear bit keeps the count
    wr(2'd0, 4);
    wr(2'd1, 1);
    idle(8);
    wr(2'd1, 0);
    rd(2'd2, rv);
    chk("R7 clear bit 0 keeps count", int'(rv[CNT_W-1:0]), 4);

    // R6 trigger sweep
    for (int m = 0; m <= 5; m++) begin
      wr(2'd0, 50);
      wr(2'd1, 2);
      p0 = pulses;
      wr(2'd1, 1);
      idle(m);
      trigIn = 1'b1;
      idle(8);
      chk("R6 trigger pulses", pulses - p0, m + 3);
      chk("R6 halted", int'(clkEn), 0);
      rd(2'd2, rv);
      chk("R6 status count", int'(rv[CNT_W-1:0]), m + 3);
      trigIn = 1'b0;
      idle(4);
    end

    // R5 zero count gives continuous clock
    wr(2'd0, 0);
    wr(2'd1, 0);
    wr(2'd1, 1);
    chk("R5 running", int'(running), 0);
    p0 = pulses; idle(10);
    chk("R5 free pulses", pulses - p0, 10);

    // R11 trigger ignored when continuous
    p0 = pulses;
    trigIn = 1'b1;
    idle(10);
    chk("R11 still free", pulses - p0, 10);
    trigIn = 1'b0;
    idle(4);
    chk("R11 clkEn", int'(clkEn), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule